// File: doc/BRIEF.md
# Branch Target Buffer on Shared Instruction-Cache Tags

This block predicts branch targets during instruction fetch without keeping full address tags in the branch target buffer itself. It holds the tag array of a small set-associative instruction cache, and the cache fill port writes that array. A fetch address first selects a set and finds the way whose stored tag matches. Each set owns a small pool of branch entries. A pool entry records only the cache way and the word offset inside the line, so a pool hit needs a cache tag hit. A few overflow entries carry full word-address tags. They take branches that find no free slot in their set's pool, and branches whose line is not resident in the cache.

The execute stage drives the update port with a resolved branch address, its target and predictor status bits. An entry that already exists is rewritten in place. Otherwise a pool slot or an overflow slot is allocated, and a rotating replacement pointer picks the victim when no slot is free. Replacing a cache line discards every pool entry that pointed at that set and way. Lookup is combinational from registered state. Updates and fills take effect at the next clock edge, and reset is synchronous.

Top module: `btb_shared_tag`

## Requirements
- R1: After synchronous reset, no fetch address hits. All tag, pool and overflow valid bits are cleared, and every replacement pointer returns to slot 0.
- R2: The PC fields are: bits [4:2] are the word offset, bits [8:5] are the set, and bits [31:9] are the cache tag. A fill writes the tag of one set and way, and that tag is valid from the next cycle. A fetch leaves the stored state unchanged.
- R3: An update whose address hits in the cache tags, with no existing entry and a free pool slot, fills the lowest free slot of that set's pool. From the next cycle a fetch of that address hits and returns the target and status.
- R4: A pool entry hits only when the fetch hits the cache in the recorded way and the word offset matches. The same offset in another way misses, and so does another offset in the same line.
- R5: When the set's pool is full and an overflow slot is free, a new branch that hits the cache takes the lowest free overflow slot and then hits on fetch.
- R6: An update whose address misses the cache tags goes to the overflow buffer. The entry then hits on fetch whatever the cache holds, and later fills do not remove it.
- R7: An update to an address that already has an entry rewrites that entry's target and status in place and allocates nothing new.
- R8: When both the pool and the overflow buffer are full, a branch that hits the cache replaces the pool slot under the set's rotating pointer. The pointer starts at slot 0 and advances by one on each such replacement.
- R9: When the overflow buffer is full, a branch that misses the cache replaces the overflow slot under its rotating pointer. That pointer starts at slot 0 and advances by one on each replacement.
- R10: A fill of a set and way invalidates every pool entry of that set recorded with that way, even if the same tag is written again. Entries of other ways stay valid.
- R11: If a fill and a pool allocation hit the same set and way in one cycle, the invalidation wins and the new entry is not left valid.
- R12: PC bits [1:0] are ignored on both the fetch and the update address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetchPc | input | 32 | Fetch address to predict |
| fetchHit | output | 1 | A branch entry matches the fetch address |
| fetchTarget | output | 32 | Predicted target, valid with fetchHit |
| fetchStatus | output | 2 | Predictor status bits of the matching entry |
| updValid | input | 1 | Execute-stage update strobe |
| updPc | input | 32 | Address of the resolved branch |
| updTarget | input | 32 | Resolved target |
| updStatus | input | 2 | Status bits to store |
| fillValid | input | 1 | Cache line replacement strobe |
| fillSet | input | 4 | Set being filled |
| fillWay | input | 2 | Way being filled |
| fillTag | input | 23 | Tag written to the set and way |

## Verification
The bench builds the block with its default shape: 4 ways, 16 sets, 8-word lines, 4 pool entries per set and 4 overflow entries. This shape is small enough to sweep completely. Every set and way gets a resident line and one branch, which fills all 64 pool slots, and each slot is checked for a hit and for misses at a wrong offset and a wrong way. Because a pool and the overflow buffer each hold only four entries, a few updates are enough to fill them, so both rotating pointers can be driven through two replacements. The same-cycle fill and update corner is also reached directly.

// File: rtl/btb_pkg.sv
package btb_pkg;
  // slot fields are carried at a fixed width and sliced by the receivers
  localparam int SLOT_W = 8;

  typedef struct packed {
    logic              wrPool;
    logic [SLOT_W-1:0] poolSlot;
    logic              bumpPoolPtr;
    logic              wrOvf;
    logic [SLOT_W-1:0] ovfSlot;
    logic              bumpOvfPtr;
  } btbStrobes_t;
endpackage

// File: rtl/btb_dp.sv
module btb_dp import btb_pkg::*; #(
  parameter int PC_W = 32,
  parameter int WAYS = 4,
  parameter int SETS = 16,
  parameter int LINE_WORDS = 8,
  parameter int POOL_N = 4,
  parameter int OVF_K = 4,
  parameter int ST_W = 2,
  localparam int OFF_W = $clog2(LINE_WORDS),
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int TAG_W = PC_W - 2 - OFF_W - IDX_W,
  localparam int FT_W = PC_W - 2,
  localparam int PSEL_W = $clog2(POOL_N),
  localparam int OSEL_W = $clog2(OVF_K)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PC_W-1:0]   fetchPc,
  input  logic [PC_W-1:0]   updPc,
  input  logic [PC_W-1:0]   updTarget,
  input  logic [ST_W-1:0]   updStatus,
  input  logic              fillValid,
  input  logic [IDX_W-1:0]  fillSet,
  input  logic [WAY_W-1:0]  fillWay,
  input  logic [TAG_W-1:0]  fillTag,
  input  btbStrobes_t       stb,
  output logic              fCacheHit,
  output logic              fPoolHit,
  output logic              fOvfHit,
  output logic [PC_W-1:0]   fPoolTgt,
  output logic [ST_W-1:0]   fPoolSt,
  output logic [PC_W-1:0]   fOvfTgt,
  output logic [ST_W-1:0]   fOvfSt,
  output logic              uCacheHit,
  output logic              uPoolHit,
  output logic [PSEL_W-1:0] uPoolIdx,
  output logic              uOvfHit,
  output logic [OSEL_W-1:0] uOvfIdx,
  output logic              uPoolFree,
  output logic [PSEL_W-1:0] uPoolFreeIdx,
  output logic              uOvfFree,
  output logic [OSEL_W-1:0] uOvfFreeIdx,
  output logic [PSEL_W-1:0] uPoolPtr,
  output logic [OSEL_W-1:0] uOvfPtr
);
  // shared cache tag array
  logic             tagV [SETS][WAYS];
  logic [TAG_W-1:0] tagA [SETS][WAYS];
  // per-set pools: way + offset only
  logic             pV   [SETS][POOL_N];
  logic [WAY_W-1:0] pWay [SETS][POOL_N];
  logic [OFF_W-1:0] pOff [SETS][POOL_N];
  logic [ST_W-1:0]  pSt  [SETS][POOL_N];
  logic [PC_W-1:0]  pTgt [SETS][POOL_N];
  logic [PSEL_W-1:0] pPtr [SETS];
  // overflow: full word-address tags
  logic             oV   [OVF_K];
  logic [FT_W-1:0]  oTag [OVF_K];
  logic [ST_W-1:0]  oSt  [OVF_K];
  logic [PC_W-1:0]  oTgt [OVF_K];
  logic [OSEL_W-1:0] oPtr;

  // two lookup ports: 0 = fetch, 1 = update
  logic [PC_W-1:0]   lkPc [2];
  logic [IDX_W-1:0]  lkSet [2];
  logic              lkCache [2];
  logic [WAY_W-1:0]  lkWay [2];
  logic              lkPool [2];
  logic [PSEL_W-1:0] lkPoolIdx [2];
  logic              lkOvf [2];
  logic [OSEL_W-1:0] lkOvfIdx [2];

  logic unusedBits;
  assign unusedBits = ^{fetchPc[1:0], updPc[1:0], stb};

  assign lkPc[0] = fetchPc;
  assign lkPc[1] = updPc;

  always_comb begin
    for (int p = 0; p < 2; p++) begin
      lkSet[p]     = lkPc[p][2+OFF_W +: IDX_W];
      lkCache[p]   = 1'b0;
      lkWay[p]     = '0;
      lkPool[p]    = 1'b0;
      lkPoolIdx[p] = '0;
      lkOvf[p]     = 1'b0;
      lkOvfIdx[p]  = '0;
      for (int w = WAYS - 1; w >= 0; w--)
        if (tagV[lkSet[p]][w] && tagA[lkSet[p]][w] == lkPc[p][PC_W-1 -: TAG_W]) begin
          lkCache[p] = 1'b1;
          lkWay[p]   = WAY_W'(w);
        end
      for (int i = POOL_N - 1; i >= 0; i--)
        if (lkCache[p] && pV[lkSet[p]][i] && pWay[lkSet[p]][i] == lkWay[p] &&
            pOff[lkSet[p]][i] == lkPc[p][2 +: OFF_W]) begin
          lkPool[p]    = 1'b1;
          lkPoolIdx[p] = PSEL_W'(i);
        end
      for (int k = OVF_K - 1; k >= 0; k--)
        if (oV[k] && oTag[k] == lkPc[p][PC_W-1:2]) begin
          lkOvf[p]    = 1'b1;
          lkOvfIdx[p] = OSEL_W'(k);
        end
    end
  end

  // fetch results
  assign fCacheHit = lkCache[0];
  assign fPoolHit  = lkPool[0];
  assign fOvfHit   = lkOvf[0];
  assign fPoolTgt  = pTgt[lkSet[0]][lkPoolIdx[0]];
  assign fPoolSt   = pSt[lkSet[0]][lkPoolIdx[0]];
  assign fOvfTgt   = oTgt[lkOvfIdx[0]];
  assign fOvfSt    = oSt[lkOvfIdx[0]];

  // update-side results for the control
  assign uCacheHit = lkCache[1];
  assign uPoolHit  = lkPool[1];
  assign uPoolIdx  = lkPoolIdx[1];
  assign uOvfHit   = lkOvf[1];
  assign uOvfIdx   = lkOvfIdx[1];
  assign uPoolPtr  = pPtr[lkSet[1]];
  assign uOvfPtr   = oPtr;

  always_comb begin
    uPoolFree    = 1'b0;
    uPoolFreeIdx = '0;
    for (int i = POOL_N - 1; i >= 0; i--)
      if (!pV[lkSet[1]][i]) begin
        uPoolFree    = 1'b1;
        uPoolFreeIdx = PSEL_W'(i);
      end
    uOvfFree    = 1'b0;
    uOvfFreeIdx = '0;
    for (int k = OVF_K - 1; k >= 0; k--)
      if (!oV[k]) begin
        uOvfFree    = 1'b1;
        uOvfFreeIdx = OSEL_W'(k);
      end
  end

  logic [PSEL_W-1:0] poolSlot;
  logic [OSEL_W-1:0] ovfSlot;
  assign poolSlot = stb.poolSlot[PSEL_W-1:0];
  assign ovfSlot  = stb.ovfSlot[OSEL_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) tagV[s][w] <= 1'b0;
        for (int i = 0; i < POOL_N; i++) pV[s][i] <= 1'b0;
        pPtr[s] <= '0;
      end
      for (int k = 0; k < OVF_K; k++) oV[k] <= 1'b0;
      oPtr <= '0;
    end else begin
      if (fillValid) begin
        tagV[fillSet][fillWay] <= 1'b1;
        tagA[fillSet][fillWay] <= fillTag;
      end
      if (stb.wrPool) begin
        pV[lkSet[1]][poolSlot]   <= 1'b1;
        pWay[lkSet[1]][poolSlot] <= lkWay[1];
        pOff[lkSet[1]][poolSlot] <= updPc[2 +: OFF_W];
        pSt[lkSet[1]][poolSlot]  <= updStatus;
        pTgt[lkSet[1]][poolSlot] <= updTarget;
        if (stb.bumpPoolPtr) pPtr[lkSet[1]] <= pPtr[lkSet[1]] + 1'b1;
      end
      if (stb.wrOvf) begin
        oV[ovfSlot]   <= 1'b1;
        oTag[ovfSlot] <= updPc[PC_W-1:2];
        oSt[ovfSlot]  <= updStatus;
        oTgt[ovfSlot] <= updTarget;
        if (stb.bumpOvfPtr) oPtr <= oPtr + 1'b1;
      end
      // line replacement drops pool entries of that set and way (last write wins)
      if (fillValid)
        for (int i = 0; i < POOL_N; i++)
          if ((stb.wrPool && lkSet[1] == fillSet && poolSlot == PSEL_W'(i)) ?
              (lkWay[1] == fillWay) : (pWay[fillSet][i] == fillWay))
            pV[fillSet][i] <= 1'b0;
    end
  end
endmodule

// File: rtl/btb_ctl.sv
module btb_ctl import btb_pkg::*; #(
  parameter int PSEL_W = 2,
  parameter int OSEL_W = 2
) (
  input  logic              updValid,
  input  logic              uCacheHit,
  input  logic              uPoolHit,
  input  logic [PSEL_W-1:0] uPoolIdx,
  input  logic              uOvfHit,
  input  logic [OSEL_W-1:0] uOvfIdx,
  input  logic              uPoolFree,
  input  logic [PSEL_W-1:0] uPoolFreeIdx,
  input  logic              uOvfFree,
  input  logic [OSEL_W-1:0] uOvfFreeIdx,
  input  logic [PSEL_W-1:0] uPoolPtr,
  input  logic [OSEL_W-1:0] uOvfPtr,
  output btbStrobes_t       stb
);
  always_comb begin
    stb = '0;
    if (updValid) begin
      if (uPoolHit) begin
        stb.wrPool   = 1'b1;
        stb.poolSlot = SLOT_W'(uPoolIdx);
      end else if (uOvfHit) begin
        stb.wrOvf   = 1'b1;
        stb.ovfSlot = SLOT_W'(uOvfIdx);
      end else if (uCacheHit && uPoolFree) begin
        stb.wrPool   = 1'b1;
        stb.poolSlot = SLOT_W'(uPoolFreeIdx);
      end else if (uOvfFree) begin
        stb.wrOvf   = 1'b1;
        stb.ovfSlot = SLOT_W'(uOvfFreeIdx);
      end else if (uCacheHit) begin
        stb.wrPool      = 1'b1;
        stb.poolSlot    = SLOT_W'(uPoolPtr);
        stb.bumpPoolPtr = 1'b1;
      end else begin
        stb.wrOvf      = 1'b1;
        stb.ovfSlot    = SLOT_W'(uOvfPtr);
        stb.bumpOvfPtr = 1'b1;
      end
    end
  end
endmodule

// File: rtl/btb_shared_tag.sv
module btb_shared_tag import btb_pkg::*; #(
  parameter int PC_W = 32,
  parameter int WAYS = 4,
  parameter int SETS = 16,
  parameter int LINE_WORDS = 8,
  parameter int POOL_N = 4,
  parameter int OVF_K = 4,
  parameter int ST_W = 2,
  localparam int OFF_W = $clog2(LINE_WORDS),
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int TAG_W = PC_W - 2 - OFF_W - IDX_W,
  localparam int PSEL_W = $clog2(POOL_N),
  localparam int OSEL_W = $clog2(OVF_K)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PC_W-1:0]  fetchPc,
  output logic             fetchHit,
  output logic [PC_W-1:0]  fetchTarget,
  output logic [ST_W-1:0]  fetchStatus,
  input  logic             updValid,
  input  logic [PC_W-1:0]  updPc,
  input  logic [PC_W-1:0]  updTarget,
  input  logic [ST_W-1:0]  updStatus,
  input  logic             fillValid,
  input  logic [IDX_W-1:0] fillSet,
  input  logic [WAY_W-1:0] fillWay,
  input  logic [TAG_W-1:0] fillTag
);
  btbStrobes_t stb;
  logic fetchCacheHit, fetchPoolHit, fetchOvfHit;
  logic [PC_W-1:0] poolTgt, ovfTgt;
  logic [ST_W-1:0] poolSt, ovfSt;
  logic uCacheHit, uPoolHit, uOvfHit, uPoolFree, uOvfFree;
  logic [PSEL_W-1:0] uPoolIdx, uPoolFreeIdx, uPoolPtr;
  logic [OSEL_W-1:0] uOvfIdx, uOvfFreeIdx, uOvfPtr;

  btb_dp #(.PC_W(PC_W), .WAYS(WAYS), .SETS(SETS), .LINE_WORDS(LINE_WORDS),
           .POOL_N(POOL_N), .OVF_K(OVF_K), .ST_W(ST_W)) dp_i (
    .clk(clk), .rst(rst), .fetchPc(fetchPc), .updPc(updPc), .updTarget(updTarget),
    .updStatus(updStatus), .fillValid(fillValid), .fillSet(fillSet), .fillWay(fillWay),
    .fillTag(fillTag), .stb(stb),
    .fCacheHit(fetchCacheHit), .fPoolHit(fetchPoolHit), .fOvfHit(fetchOvfHit),
    .fPoolTgt(poolTgt), .fPoolSt(poolSt), .fOvfTgt(ovfTgt), .fOvfSt(ovfSt),
    .uCacheHit(uCacheHit), .uPoolHit(uPoolHit), .uPoolIdx(uPoolIdx),
    .uOvfHit(uOvfHit), .uOvfIdx(uOvfIdx), .uPoolFree(uPoolFree),
    .uPoolFreeIdx(uPoolFreeIdx), .uOvfFree(uOvfFree), .uOvfFreeIdx(uOvfFreeIdx),
    .uPoolPtr(uPoolPtr), .uOvfPtr(uOvfPtr));

  btb_ctl #(.PSEL_W(PSEL_W), .OSEL_W(OSEL_W)) ctl_i (
    .updValid(updValid), .uCacheHit(uCacheHit), .uPoolHit(uPoolHit),
    .uPoolIdx(uPoolIdx), .uOvfHit(uOvfHit), .uOvfIdx(uOvfIdx),
    .uPoolFree(uPoolFree), .uPoolFreeIdx(uPoolFreeIdx), .uOvfFree(uOvfFree),
    .uOvfFreeIdx(uOvfFreeIdx), .uPoolPtr(uPoolPtr), .uOvfPtr(uOvfPtr), .stb(stb));

  // pool entries take priority; they count only on a resident line
  logic poolSel;
  assign poolSel     = fetchPoolHit & fetchCacheHit;
  assign fetchHit    = poolSel | fetchOvfHit;
  assign fetchTarget = poolSel ? poolTgt : ovfTgt;
  assign fetchStatus = poolSel ? poolSt : ovfSt;
endmodule

// File: rtl/btb_shared_tag_chk.sv
module btb_shared_tag_chk #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic [PC_W-1:0] fetchPc,
  input logic            fetchHit,
  input logic [PC_W-1:0] fetchTarget,
  input logic            updValid,
  input logic [PC_W-1:0] updPc,
  input logic [PC_W-1:0] updTarget,
  input logic            fillValid,
  input logic            wrPool,
  input logic            wrOvf
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !fetchHit);

  // R3
  upd_visible_chk: assert property (@(posedge clk) disable iff (rst)
    (updValid && !fillValid) |=>
      (fetchPc[PC_W-1:2] != $past(updPc[PC_W-1:2]) ||
       (fetchHit && fetchTarget == $past(updTarget))));

  // R7
  single_write_chk: assert property (@(posedge clk) disable iff (rst)
    updValid |-> $onehot({wrPool, wrOvf}));

  // R7
  no_spurious_write_chk: assert property (@(posedge clk) disable iff (rst)
    !updValid |-> (!wrPool && !wrOvf));

  // R2
  fetch_no_side_effect_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(updValid) && !$past(fillValid) && $stable(fetchPc)) |->
      (fetchHit == $past(fetchHit) && (!fetchHit || fetchTarget == $past(fetchTarget))));
endmodule

bind btb_shared_tag btb_shared_tag_chk #(.PC_W(PC_W)) chk_i (
  .clk(clk), .rst(rst), .fetchPc(fetchPc), .fetchHit(fetchHit),
  .fetchTarget(fetchTarget), .updValid(updValid), .updPc(updPc),
  .updTarget(updTarget), .fillValid(fillValid),
  .wrPool(stb.wrPool), .wrOvf(stb.wrOvf));

// File: tb/btb_shared_tag_tb.sv
module btb_shared_tag_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] fetchPc = '0;
  logic        fetchHit;
  logic [31:0] fetchTarget;
  logic [1:0]  fetchStatus;
  logic        updValid = 1'b0;
  logic [31:0] updPc = '0;
  logic [31:0] updTarget = '0;
  logic [1:0]  updStatus = '0;
  logic        fillValid = 1'b0;
  logic [3:0]  fillSet = '0;
  logic [1:0]  fillWay = '0;
  logic [22:0] fillTag = '0;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  btb_shared_tag dut_i (
    .clk(clk), .rst(rst), .fetchPc(fetchPc), .fetchHit(fetchHit),
    .fetchTarget(fetchTarget), .fetchStatus(fetchStatus), .updValid(updValid),
    .updPc(updPc), .updTarget(updTarget), .updStatus(updStatus),
    .fillValid(fillValid), .fillSet(fillSet), .fillWay(fillWay), .fillTag(fillTag));

  function automatic logic [31:0] mkPc(int tag, int s, int o);
    return (32'(tag) << 9) | (32'(s) << 5) | (32'(o) << 2);
  endfunction

  function automatic int tagOf(int s, int w);
    return 'h100 + s * 4 + w;
  endfunction

  function automatic logic [31:0] tgtOf(int s, int w);
    return 32'h8000_0000 + 32'(s * 256 + w * 16);
  endfunction

  task automatic doReset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic fill(int s, int w, int tag);
    @(negedge clk);
    fillValid = 1'b1; fillSet = 4'(s); fillWay = 2'(w); fillTag = 23'(tag);
    @(negedge clk);
    fillValid = 1'b0;
  endtask

  task automatic upd(logic [31:0] pc, logic [31:0] tgt, logic [1:0] st);
    @(negedge clk);
    updValid = 1'b1; updPc = pc; updTarget = tgt; updStatus = st;
    @(negedge clk);
    updValid = 1'b0;
  endtask

  task automatic look(logic [31:0] pc, logic expHit, logic [31:0] expTgt,
                      logic [1:0] expSt, string req);
    fetchPc = pc;
    #1;
    checks++;
    if (fetchHit !== expHit ||
        (expHit && (fetchTarget !== expTgt || fetchStatus !== expSt))) begin
      errors++;
      $display("FAIL %s pc=%h actual hit=%b tgt=%h st=%b expected hit=%b tgt=%h st=%b",
               req, pc, fetchHit, fetchTarget, fetchStatus, expHit, expTgt, expSt);
    end
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    doReset();
    // R1: nothing hits after reset
    look(mkPc(0, 0, 0), 1'b0, '0, '0, "R1");
    look(mkPc(tagOf(3, 1), 3, 4), 1'b0, '0, '0, "R1");

    // R2/R3 sweep: one branch per set and way fills every pool slot
    for (int s = 0; s < 16; s++)
      for (int w = 0; w < 4; w++) begin
        fill(s, w, tagOf(s, w));
        upd(mkPc(tagOf(s, w), s, (s + w) % 8), tgtOf(s, w), 2'(w));
      end
    for (int s = 0; s < 16; s++)
      for (int w = 0; w < 4; w++) begin
        look(mkPc(tagOf(s, w), s, (s + w) % 8), 1'b1, tgtOf(s, w), 2'(w), "R3");
        // R4: wrong offset, same line
        look(mkPc(tagOf(s, w), s, (s + w + 1) % 8), 1'b0, '0, '0, "R4");
        // R4: same offset, other way
        look(mkPc(tagOf(s, (w + 1) % 4), s, (s + w) % 8), 1'b0, '0, '0, "R4");
      end
    // R12: low address bits ignored on fetch
    look(mkPc(tagOf(5, 2), 5, 7) | 32'h3, 1'b1, tgtOf(5, 2), 2'd2, "R12");

    // R10: replacing set 2 way 1 drops its branch even with the same tag
    fill(2, 1, 'h7777);
    look(mkPc(tagOf(2, 1), 2, 3), 1'b0, '0, '0, "R10");
    fill(2, 1, tagOf(2, 1));
    look(mkPc(tagOf(2, 1), 2, 3), 1'b0, '0, '0, "R10");
    look(mkPc(tagOf(2, 0), 2, 2), 1'b1, tgtOf(2, 0), 2'd0, "R10");
    look(mkPc(tagOf(2, 2), 2, 4), 1'b1, tgtOf(2, 2), 2'd2, "R10");

    // R1: reset clears everything again
    doReset();
    look(mkPc(tagOf(5, 2), 5, 7), 1'b0, '0, '0, "R1");

    // R5/R8/R9: set 3 way 0, pool then overflow then replacement
    fill(3, 0, 'h55);
    for (int o = 0; o < 8; o++)
      upd(mkPc('h55, 3, o) | 32'h2, 32'h1000 + 32'(o * 4), 2'(o));   // R12 on update
    for (int o = 0; o < 8; o++)
      look(mkPc('h55, 3, o), 1'b1, 32'h1000 + 32'(o * 4), 2'(o), o < 4 ? "R3" : "R5");
    fill(3, 1, 'h66);
    upd(mkPc('h66, 3, 0), 32'h2000, 2'd1);
    look(mkPc('h66, 3, 0), 1'b1, 32'h2000, 2'd1, "R8");
    look(mkPc('h55, 3, 0), 1'b0, '0, '0, "R8");
    look(mkPc('h55, 3, 1), 1'b1, 32'h1004, 2'd1, "R8");
    upd(mkPc('h66, 3, 1), 32'h2004, 2'd2);
    look(mkPc('h55, 3, 1), 1'b0, '0, '0, "R8");
    look(mkPc('h55, 3, 2), 1'b1, 32'h1008, 2'd2, "R8");
    look(mkPc('h66, 3, 1), 1'b1, 32'h2004, 2'd2, "R8");
    // R9: cache-miss branches rotate through the overflow buffer
    upd(mkPc('h99, 5, 0), 32'h3000, 2'd3);
    look(mkPc('h99, 5, 0), 1'b1, 32'h3000, 2'd3, "R9");
    look(mkPc('h55, 3, 4), 1'b0, '0, '0, "R9");
    look(mkPc('h55, 3, 5), 1'b1, 32'h1014, 2'd1, "R9");
    upd(mkPc('h99, 5, 1), 32'h3004, 2'd0);
    look(mkPc('h55, 3, 5), 1'b0, '0, '0, "R9");
    look(mkPc('h55, 3, 6), 1'b1, 32'h1018, 2'd2, "R9");

    // R7: in-place rewrite with a full pool and free overflow
    doReset();
    fill(4, 2, 'h44);
    for (int o = 0; o < 4; o++) upd(mkPc('h44, 4, o), 32'h4000 + 32'(o), 2'd0);
    upd(mkPc('h44, 4, 2), 32'h4abc, 2'd3);
    for (int k = 0; k < 4; k++) upd(mkPc('h200 + k, 9, 0), 32'h5000 + 32'(k), 2'd1);
    look(mkPc('h44, 4, 2), 1'b1, 32'h4abc, 2'd3, "R7");
    look(mkPc('h44, 4, 0), 1'b1, 32'h4000, 2'd0, "R7");
    look(mkPc('h44, 4, 3), 1'b1, 32'h4003, 2'd0, "R7");
    for (int k = 0; k < 4; k++)
      look(mkPc('h200 + k, 9, 0), 1'b1, 32'h5000 + 32'(k), 2'd1, "R7");

    // R6: overflow entry survives fills that make its line resident and evict it
    doReset();
    upd(mkPc('h321, 6, 5), 32'h6000, 2'd2);
    look(mkPc('h321, 6, 5), 1'b1, 32'h6000, 2'd2, "R6");
    fill(6, 0, 'h321);
    look(mkPc('h321, 6, 5), 1'b1, 32'h6000, 2'd2, "R6");
    fill(6, 0, 'h123);
    look(mkPc('h321, 6, 5), 1'b1, 32'h6000, 2'd2, "R6");

    // R11: same-cycle fill and allocation on one set and way
    fill(7, 2, 'hab);
    @(negedge clk);
    updValid = 1'b1; updPc = mkPc('hab, 7, 1); updTarget = 32'h7000; updStatus = 2'd1;
    fillValid = 1'b1; fillSet = 4'd7; fillWay = 2'd2; fillTag = 23'hab;
    @(negedge clk);
    updValid = 1'b0; fillValid = 1'b0;
    look(mkPc('hab, 7, 1), 1'b0, '0, '0, "R11");
    upd(mkPc('hab, 7, 1), 32'h7004, 2'd2);
    look(mkPc('hab, 7, 1), 1'b1, 32'h7004, 2'd2, "R11");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule